// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block paints a 64 by 64 pixel two-plane cursor over a stream of 32-bit display pixels. A display pipeline feeds it each pixel along with that pixel's raster column and line counters, its valid flag and its horizontal and vertical sync flags. The block hands the pixel on one clock later. The pixel is replaced by cursor colour where the cursor covers it, inverted or left alone where the cursor image says so, and passed through untouched everywhere else.

The cursor image sits in an internal byte store that a host loads through a simple write port. Each cursor line takes sixteen bytes. The first eight bytes hold the mask plane and the next eight hold the pattern plane. The two bits that a pixel takes from these planes choose one of four outcomes: colour 0, colour 1, transparent, or the complement of the underlying pixel.

The cursor position and the two colours are held in a pending copy. They pass to the active copy only when vertical blank begins. A lock input holds back both that transfer and any writes to the shape store, so a host can rewrite the whole cursor without a half-updated image reaching the screen.

Top module: `hw_cursor_overlay`

## Requirements
- R1: For a covered pixel with mask bit 0, the output is {colour0, 8'hFF} when the pattern bit is 0 and {colour1, 8'hFF} when the pattern bit is 1.
- R2: For a covered pixel with mask bit 1 and pattern bit 0, the output equals the input pixel.
- R3: For a covered pixel with mask bit 1 and pattern bit 1, the output is the bitwise complement of the input pixel.
- R4: Cursor pixel (column c, row r) takes its mask bit from store byte r*16 + c/8 and its pattern bit from byte r*16 + 8 + c/8, at bit 7 - (c mod 8), so the MSB of a byte is the leftmost of its eight pixels.
- R5: Lines outside [cursor_y, cursor_y+63] pass through unchanged.
- R6: Columns outside [cursor_x, cursor_x+63], and any column at or beyond the active width, pass through unchanged, with no wrap onto the next line.
- R7: Lines greater than the last visible line pass through unchanged.
- R8: With the enable input low, or with the input valid flag low, the pixel passes through unchanged.
- R9: The position input packs X in bits 31:16 and Y in bits 15:0. Position and both colours become active on the first clock on which vertical blank is high after being low, and changes to them at other times have no effect.
- R10: While the lock input is high, shape store writes are dropped and the vertical-blank transfer is skipped.
- R11: Pixel data, valid, hsync and vsync each leave exactly one clock after they enter.
- R12: During reset, all outputs and the active position and colours are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_en | input | 1 | Cursor display enable |
| cur_lock | input | 1 | Freezes shape writes and pending-to-active transfer |
| cur_pos | input | 2*COORD_W | Pending position, X high half, Y low half |
| cur_color0 | input | 24 | Pending colour 0 |
| cur_color1 | input | 24 | Pending colour 1 |
| h_active | input | COORD_W | Active width; columns at or above are clipped |
| v_last | input | COORD_W | Last visible line index |
| vblank | input | 1 | Vertical blank level |
| shp_we | input | 1 | Shape store byte write strobe |
| shp_addr | input | SHP_AW | Shape store byte address |
| shp_data | input | 8 | Shape store byte data |
| raster_x | input | COORD_W | Column of the incoming pixel |
| raster_y | input | COORD_W | Line of the incoming pixel |
| pix_in | input | 32 | Incoming pixel |
| pix_valid | input | 1 | Incoming pixel valid |
| hsync_in | input | 1 | Incoming horizontal sync |
| vsync_in | input | 1 | Incoming vertical sync |
| pix_out | output | 32 | Outgoing pixel |
| pix_valid_out | output | 1 | Outgoing valid |
| hsync_out | output | 1 | Outgoing horizontal sync |
| vsync_out | output | 1 | Outgoing vertical sync |

## Verification
A host write to the shape store and a pixel lookup of the very same byte can land on one clock edge. The bench provokes this by strobing a write to byte 0 while it presents the pixel at the cursor's top-left corner. It expects that pixel to show the old byte contents, and the pixel presented next to show the new contents. The vertical-blank transfer can likewise meet a lock change. The bench holds the lock across a blank and checks that the cursor keeps its old place, colours and shape until the first blank after the lock is released.

// File: rtl/hco_pkg.sv
package hco_pkg;
  localparam int PIX_W   = 32;
  localparam int COLOR_W = 24;
  localparam int FILL_W  = PIX_W - COLOR_W;

  // Cursor plane code {mask, pattern}
  typedef enum logic [1:0] {
    MIX_COLOR0 = 2'b00,
    MIX_COLOR1 = 2'b01,
    MIX_CLEAR  = 2'b10,
    MIX_INVERT = 2'b11
  } mix_e;

  function automatic logic [PIX_W-1:0] cursor_mix(
    input logic               mask_b,
    input logic               pat_b,
    input logic [PIX_W-1:0]   under,
    input logic [COLOR_W-1:0] c0,
    input logic [COLOR_W-1:0] c1
  );
    mix_e code;
    code = mix_e'({mask_b, pat_b});
    case (code)
      MIX_COLOR0: cursor_mix = {c0, {FILL_W{1'b1}}};
      MIX_COLOR1: cursor_mix = {c1, {FILL_W{1'b1}}};
      MIX_CLEAR:  cursor_mix = under;
      default:    cursor_mix = ~under;
    endcase
  endfunction
endpackage

// File: rtl/hco_shape_ram.sv
module hco_shape_ram #(
  parameter  int CUR_DIM = 64,
  localparam int CW      = $clog2(CUR_DIM),
  localparam int BPR     = CUR_DIM / 4,
  localparam int DEPTH   = CUR_DIM * BPR,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [CW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic          mask_bit,
  output logic          pat_bit
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] mask_addr;
  logic [AW-1:0] pat_addr;
  logic [2:0]    bit_idx;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // row base, plane select (mask first), then byte lane within the plane
  assign mask_addr = {rd_row, 1'b0, rd_col[CW-1:3]};
  assign pat_addr  = {rd_row, 1'b1, rd_col[CW-1:3]};
  assign bit_idx   = 3'd7 - rd_col[2:0];
  assign mask_bit  = mem[mask_addr][bit_idx];
  assign pat_bit   = mem[pat_addr][bit_idx];
endmodule

// File: rtl/hco_shadow.sv
module hco_shadow #(
  parameter int COORD_W = 16,
  parameter int COLOR_W = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vblank,
  input  logic                 lock,
  input  logic [2*COORD_W-1:0] pos_in,
  input  logic [COLOR_W-1:0]   c0_in,
  input  logic [COLOR_W-1:0]   c1_in,
  output logic [COORD_W-1:0]   act_x,
  output logic [COORD_W-1:0]   act_y,
  output logic [COLOR_W-1:0]   act_c0,
  output logic [COLOR_W-1:0]   act_c1,
  output logic                 load_evt
);
  logic vb_q;

  assign load_evt = vblank & ~vb_q & ~lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      vb_q   <= 1'b0;
      act_x  <= '0;
      act_y  <= '0;
      act_c0 <= '0;
      act_c1 <= '0;
    end else begin
      vb_q <= vblank;
      if (load_evt) begin
        act_x  <= pos_in[2*COORD_W-1:COORD_W];
        act_y  <= pos_in[COORD_W-1:0];
        act_c0 <= c0_in;
        act_c1 <= c1_in;
      end
    end
  end
endmodule

// File: rtl/hw_cursor_overlay.sv
module hw_cursor_overlay #(
  parameter  int COORD_W = 16,
  parameter  int CUR_DIM = 64,
  localparam int SHP_AW  = $clog2(CUR_DIM * CUR_DIM / 4)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cur_en,
  input  logic                 cur_lock,
  input  logic [2*COORD_W-1:0] cur_pos,
  input  logic [23:0]          cur_color0,
  input  logic [23:0]          cur_color1,
  input  logic [COORD_W-1:0]   h_active,
  input  logic [COORD_W-1:0]   v_last,
  input  logic                 vblank,
  input  logic                 shp_we,
  input  logic [SHP_AW-1:0]    shp_addr,
  input  logic [7:0]           shp_data,
  input  logic [COORD_W-1:0]   raster_x,
  input  logic [COORD_W-1:0]   raster_y,
  input  logic [31:0]          pix_in,
  input  logic                 pix_valid,
  input  logic                 hsync_in,
  input  logic                 vsync_in,
  output logic [31:0]          pix_out,
  output logic                 pix_valid_out,
  output logic                 hsync_out,
  output logic                 vsync_out
);
  import hco_pkg::*;
  localparam int CW = $clog2(CUR_DIM);

  // offset of a raster coordinate from the cursor origin, with borrow bit
  function automatic logic [COORD_W:0] span_off(
    input logic [COORD_W-1:0] coord,
    input logic [COORD_W-1:0] origin
  );
    span_off = {1'b0, coord} - {1'b0, origin};
  endfunction

  function automatic logic in_span(input logic [COORD_W:0] off);
    in_span = !off[COORD_W] && (off[COORD_W-1:0] < COORD_W'(CUR_DIM));
  endfunction

  logic [COORD_W-1:0] act_x, act_y;
  logic [23:0]        act_c0, act_c1;
  logic               load_evt;
  logic [COORD_W:0]   dx, dy;
  logic               hit;
  logic               mask_b, pat_b;
  logic [31:0]        mixed;

  hco_shadow #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .vblank   (vblank),
    .lock     (cur_lock),
    .pos_in   (cur_pos),
    .c0_in    (cur_color0),
    .c1_in    (cur_color1),
    .act_x    (act_x),
    .act_y    (act_y),
    .act_c0   (act_c0),
    .act_c1   (act_c1),
    .load_evt (load_evt)
  );

  assign dx = span_off(raster_x, act_x);
  assign dy = span_off(raster_y, act_y);

  hco_shape_ram #(.CUR_DIM(CUR_DIM)) u_ram (
    .clk      (clk),
    .wr_en    (shp_we & ~cur_lock),
    .wr_addr  (shp_addr),
    .wr_data  (shp_data),
    .rd_row   (dy[CW-1:0]),
    .rd_col   (dx[CW-1:0]),
    .mask_bit (mask_b),
    .pat_bit  (pat_b)
  );

  assign hit = cur_en && pix_valid && in_span(dx) && in_span(dy) &&
               (raster_x < h_active) && (raster_y <= v_last);

  assign mixed = cursor_mix(mask_b, pat_b, pix_in, act_c0, act_c1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_out       <= '0;
      pix_valid_out <= 1'b0;
      hsync_out     <= 1'b0;
      vsync_out     <= 1'b0;
    end else begin
      pix_out       <= hit ? mixed : pix_in;
      pix_valid_out <= pix_valid;
      hsync_out     <= hsync_in;
      vsync_out     <= vsync_in;
    end
  end
endmodule

// File: rtl/hco_chk.sv
module hco_chk #(
  parameter int COORD_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cur_en,
  input logic                 cur_lock,
  input logic                 vblank,
  input logic [2*COORD_W-1:0] cur_pos,
  input logic [COORD_W-1:0]   raster_x,
  input logic [COORD_W-1:0]   raster_y,
  input logic [COORD_W-1:0]   h_active,
  input logic [COORD_W-1:0]   v_last,
  input logic [31:0]          pix_in,
  input logic                 pix_valid,
  input logic                 hsync_in,
  input logic [31:0]          pix_out,
  input logic                 pix_valid_out,
  input logic                 hsync_out,
  input logic                 hit,
  input logic                 load_evt,
  input logic [COORD_W-1:0]   act_x,
  input logic [COORD_W-1:0]   act_y
);
  // R8
  disabled_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !cur_en |=> pix_out == $past(pix_in));

  // R11
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> pix_valid_out);

  // R11
  invalid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !pix_valid_out);

  // R11
  hsync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    hsync_in |=> hsync_out);

  // R9
  pos_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (act_x == $past(cur_pos[2*COORD_W-1:COORD_W])) &&
                 (act_y == $past(cur_pos[COORD_W-1:0])));

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_lock && vblank) |=> $stable(act_x) && $stable(act_y));

  // R6
  hclip_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> raster_x < h_active);

  // R7
  vclip_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> raster_y <= v_last);

  // R5
  top_edge_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> raster_y >= act_y);
endmodule

bind hw_cursor_overlay hco_chk #(.COORD_W(COORD_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cur_en        (cur_en),
  .cur_lock      (cur_lock),
  .vblank        (vblank),
  .cur_pos       (cur_pos),
  .raster_x      (raster_x),
  .raster_y      (raster_y),
  .h_active      (h_active),
  .v_last        (v_last),
  .pix_in        (pix_in),
  .pix_valid     (pix_valid),
  .hsync_in      (hsync_in),
  .pix_out       (pix_out),
  .pix_valid_out (pix_valid_out),
  .hsync_out     (hsync_out),
  .hit           (hit),
  .load_evt      (load_evt),
  .act_x         (act_x),
  .act_y         (act_y)
);

// File: tb/sim_hw_cursor_overlay.sv
module sim_hw_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst;
  logic        cur_en, cur_lock, vblank, shp_we;
  logic [31:0] cur_pos;
  logic [23:0] cur_color0, cur_color1;
  logic [15:0] h_active, v_last, raster_x, raster_y;
  logic [9:0]  shp_addr;
  logic [7:0]  shp_data;
  logic [31:0] pix_in;
  logic        pix_valid, hsync_in, vsync_in;
  logic [31:0] pix_out;
  logic        pix_valid_out, hsync_out, vsync_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench-side model of the expected active state
  logic [7:0]  model [1024];
  int          m_cx, m_cy, m_ha, m_vl;
  logic [23:0] m_c0, m_c1;
  logic        m_en;

  always #4 clk = ~clk;

  hw_cursor_overlay u0 (
    .clk(clk), .rst(rst), .cur_en(cur_en), .cur_lock(cur_lock),
    .cur_pos(cur_pos), .cur_color0(cur_color0), .cur_color1(cur_color1),
    .h_active(h_active), .v_last(v_last), .vblank(vblank),
    .shp_we(shp_we), .shp_addr(shp_addr), .shp_data(shp_data),
    .raster_x(raster_x), .raster_y(raster_y), .pix_in(pix_in),
    .pix_valid(pix_valid), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .pix_out(pix_out), .pix_valid_out(pix_valid_out),
    .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 73 + (a >> 3) * 29 + 17);
  endfunction

  function automatic logic [31:0] pin_of(input int x, input int y);
    return 32'(x * 32'h01030507) ^ 32'(y * 32'h00C3A511) ^ 32'h5A00_F00F;
  endfunction

  function automatic logic [31:0] expect_pix(input int x, input int y,
                                             input logic [31:0] pin,
                                             output string tag);
    int  r, c;
    logic mb, pb;
    if (!m_en) begin tag = "R8"; return pin; end
    if (y < m_cy || y >= m_cy + 64) begin tag = "R5"; return pin; end
    if (x < m_cx || x >= m_cx + 64) begin tag = "R6"; return pin; end
    if (y > m_vl) begin tag = "R7"; return pin; end
    if (x >= m_ha) begin tag = "R6"; return pin; end
    r  = y - m_cy;
    c  = x - m_cx;
    mb = model[r * 16 + c / 8][7 - c % 8];        // R4 byte and bit order
    pb = model[r * 16 + 8 + c / 8][7 - c % 8];
    if (!mb) begin tag = "R1 R4"; return pb ? {m_c1, 8'hFF} : {m_c0, 8'hFF}; end
    if (!pb) begin tag = "R2 R4"; return pin; end
    tag = "R3 R4";
    return ~pin;
  endfunction

  // present one pixel at a negedge, compare one clock later
  task automatic put_pix(input int x, input int y);
    string       tag;
    logic [31:0] exp;
    raster_x  = 16'(x);
    raster_y  = 16'(y);
    pix_in    = pin_of(x, y);
    pix_valid = 1'b1;
    exp = expect_pix(x, y, pin_of(x, y), tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, pix_out, exp);
  endtask

  task automatic pulse_vblank();
    vblank = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vblank = 1'b0;
    if (!cur_lock) begin
      m_cx = int'(cur_pos[31:16]);
      m_cy = int'(cur_pos[15:0]);
      m_c0 = cur_color0;
      m_c1 = cur_color1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cur_en = 1'b0; cur_lock = 1'b0; vblank = 1'b0; shp_we = 1'b0;
    cur_pos = 32'h0; cur_color0 = 24'h0; cur_color1 = 24'h0;
    h_active = 16'd150; v_last = 16'd110; raster_x = '0; raster_y = '0;
    shp_addr = '0; shp_data = '0; pix_in = 32'hDEAD_BEEF; pix_valid = 1'b1;
    hsync_in = 1'b1; vsync_in = 1'b1;
    m_cx = 0; m_cy = 0; m_c0 = '0; m_c1 = '0; m_en = 1'b0; m_ha = 150; m_vl = 110;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 pix", pix_out, 32'h0);
    chk("R12 side", {29'd0, pix_valid_out, hsync_out, vsync_out}, 32'h0);
    rst = 1'b0;
    pix_valid = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0;
    @(negedge clk);

    // load the whole shape store
    for (int a = 0; a < 1024; a++) begin
      model[a] = pat(a);
      shp_we = 1'b1; shp_addr = 10'(a); shp_data = pat(a);
      @(negedge clk);
    end
    shp_we = 1'b0;

    // R9 position packing and vblank transfer
    cur_pos = {16'd100, 16'd50};
    cur_color0 = 24'h12_34_56; cur_color1 = 24'hA5_C3_0F;
    pulse_vblank();
    cur_en = 1'b1; m_en = 1'b1;

    // sweep around the cursor, covering clip at h_active and v_last
    for (int y = 46; y <= 118; y++)
      for (int x = 96; x <= 168; x++)
        put_pix(x, y);

    // R9 pending change without blank has no effect
    cur_pos = {16'd10, 16'd5};
    cur_color0 = 24'h00_00_FF;
    put_pix(100, 50);
    put_pix(10, 5);

    // R10 lock: shape write dropped and blank transfer skipped
    cur_lock = 1'b1;
    shp_we = 1'b1; shp_addr = 10'd0; shp_data = ~model[0];
    @(negedge clk);
    shp_we = 1'b0;
    pulse_vblank();
    put_pix(100, 50);
    put_pix(107, 50);
    put_pix(10, 5);
    cur_lock = 1'b0;
    pulse_vblank();
    for (int x = 8; x < 20; x++) put_pix(x, 5);   // R10 old byte 0 kept, R9 new place

    // collision: write byte 0 in the same cycle as reading it
    shp_we = 1'b1; shp_addr = 10'd0; shp_data = ~model[0];
    put_pix(10, 5);
    shp_we = 1'b0;
    model[0] = ~model[0];
    for (int x = 10; x < 18; x++) put_pix(x, 5);  // R4 new contents visible

    // R8 enable low and valid low
    cur_en = 1'b0; m_en = 1'b0;
    put_pix(12, 6);
    cur_en = 1'b1; m_en = 1'b1;
    raster_x = 16'd12; raster_y = 16'd6; pix_in = 32'h0BAD_F00D; pix_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 invalid", pix_out, 32'h0BAD_F00D);

    // R11 sideband latency, all combinations
    for (int k = 0; k < 8; k++) begin
      pix_valid = k[0]; hsync_in = k[1]; vsync_in = k[2];
      raster_y = 16'd300;
      @(posedge clk); @(negedge clk);
      chk("R11 side", {29'd0, pix_valid_out, hsync_out, vsync_out},
          {29'd0, k[0], k[1], k[2]});
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule